// File: doc/BRIEF.md
# Compare-Match Periodic Timer

This block holds several independent 16-bit counting channels behind one byte-addressed register port. Each channel counts ticks from its own prescaler (every clock, or one clock in 4, 16 or 64). When the count equals the channel's compare value, the channel raises a sticky match flag. If a control code selects it, the same tick also returns the counter to zero, so the channel produces a fixed period of (compare + 1) ticks. A single shared run register holds one bit per channel and starts or stops each channel. Each channel drives an interrupt line that follows its match flag, gated by an enable bit.

Software configures a channel by writing its control, compare, counter and enable registers, then sets the channel's run bit. On each interrupt it acknowledges the match: it reads the status register while the flag is set, then writes a zero to the flag bit. Accesses take one cycle. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `cmt_timer`

## Requirements
- R1: After reset every register reads 0, every run bit is 0, `irq` is all zero and `bus_rdata` is 0.
- R2: Channel c occupies addresses 16*c to 16*c+15. Its registers sit at these offsets: control 0, mode 1, I/O control 2, interrupt enable 4, status 5, counter 6, compare 8. The counter and compare registers are 16 bits wide. The other five registers are 8 bits wide, store `bus_wdata[7:0]` and read back with bits 15:8 at zero. Any other offset reads 0 and ignores writes. Read data appears on the cycle after `bus_re`.
- R3: The run register is at address 16*NUM_CH (0x30 by default). Bit c of it runs channel c. A channel whose run bit is 0 keeps its counter unchanged, except when software writes the counter.
- R4: Control bits [1:0] set the tick rate. 00 gives one tick per clock, 01 one per 4 clocks, 10 one per 16 and 11 one per 64. Control bit 2 has no effect. With control 0x23, compare 1 and the counter preset to 0, the flag sets on the 128th clock after the run bit is written.
- R5: When control bits [7:5] are 001, a tick that finds the counter equal to the compare value sets the counter to 0. The period is therefore (compare + 1) ticks.
- R6: When control bits [7:5] hold any other code, the counter runs freely and wraps from 0xFFFF to 0. A match still sets the flag.
- R7: The match flag is status bit 0 (other status bits read 0). It becomes 1 at the clock edge of a tick that finds the counter equal to the compare value.
- R8: A status write with bit 0 at zero clears the flag only when, since the last status write, a status read returned the flag as 1. Every status write cancels that permission. A write with bit 0 at one leaves the flag unchanged.
- R9: `irq[c]` is high exactly while channel c's flag is 1 and bit 0 of its interrupt enable register is 1.
- R10: Clearing a run bit resets that channel's prescaler. After a restart, the first tick comes a full prescale period later.
- R11: A counter write in the same cycle as a tick loads the written value. A match in the same cycle as an accepted clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | CNT_W | Write data (8-bit registers use bits 7:0) |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
A wrong prescaler or counter state shows up at the ports in two ways. The interrupt edge moves by whole ticks. Counter reads drift from the expected count on the first read after the fault. Both are visible within one prescale period at most. A wrong acknowledge-permission state shows up at once as an interrupt line that stays high, or drops, right after a status write. A wrong run bit stops or moves the interrupt edge of only that channel, which keeps channels from masking each other's faults. The bench keeps a behavioural model of every channel and compares the interrupt vector and the read data on every cycle. It adds hand-counted latency checks for the divide-by-4, divide-by-64 and restart cases.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int OFF_W = 4;
  localparam int SEL_W = 2;

  localparam logic [OFF_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [OFF_W-1:0] OFF_MODE = 4'h1;
  localparam logic [OFF_W-1:0] OFF_IOC  = 4'h2;
  localparam logic [OFF_W-1:0] OFF_IEN  = 4'h4;
  localparam logic [OFF_W-1:0] OFF_STAT = 4'h5;
  localparam logic [OFF_W-1:0] OFF_CNT  = 4'h6;
  localparam logic [OFF_W-1:0] OFF_CMP  = 4'h8;

  localparam logic [2:0] CLR_ON_MATCH = 3'b001;

  typedef struct packed {
    logic ctrl;
    logic mode;
    logic ioc;
    logic ien;
    logic stat;
    logic cnt;
    logic cmp;
  } reg_hit_t;

  function automatic reg_hit_t decode_off(logic [OFF_W-1:0] off);
    reg_hit_t h;
    h.ctrl = (off == OFF_CTRL);
    h.mode = (off == OFF_MODE);
    h.ioc  = (off == OFF_IOC);
    h.ien  = (off == OFF_IEN);
    h.stat = (off == OFF_STAT);
    h.cnt  = (off == OFF_CNT);
    h.cmp  = (off == OFF_CMP);
    return h;
  endfunction

  function automatic logic is_byte_reg(logic [OFF_W-1:0] off);
    reg_hit_t h;
    h = decode_off(off);
    return h.ctrl | h.mode | h.ioc | h.ien | h.stat;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  // largest division is 4**(2**SEL_W - 1); count width follows
  localparam int PS_W = 2 * ((1 << SEL_W) - 1);

  logic [PS_W-1:0] pc_q;
  logic [PS_W-1:0] lim;

  always_comb begin
    lim = PS_W'((32'd1 << (32'd2 * 32'(sel_i))) - 32'd1);
  end

  assign tick_o = run_i && (pc_q >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (!run_i || tick_o) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  // R10
  presc_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (pc_q == '0) && !(tick_o && sel_i != '0));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rval_o,
  output logic             irq_o
);
  logic [7:0]       ctrl_q, mode_q, ioc_q, ien_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             flag_q, armed_q;
  logic             tick;
  logic             match;
  logic             clr_mode;
  reg_hit_t         hit;
  logic             wr_cnt, wr_stat, rd_stat, ack_ok;

  cmt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_i),
    .sel_i  (ctrl_q[SEL_W-1:0]),
    .tick_o (tick)
  );

  assign hit      = decode_off(off_i);
  assign wr_cnt   = wr_i && hit.cnt;
  assign wr_stat  = wr_i && hit.stat;
  assign rd_stat  = rd_i && hit.stat;
  assign ack_ok   = wr_stat && armed_q && !wdata_i[0];
  assign clr_mode = (ctrl_q[7:5] == CLR_ON_MATCH);
  assign match    = tick && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      ioc_q   <= '0;
      ien_q   <= '0;
      cnt_q   <= '0;
      cmp_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_i && hit.ctrl) ctrl_q <= wdata_i[7:0];
      if (wr_i && hit.mode) mode_q <= wdata_i[7:0];
      if (wr_i && hit.ioc)  ioc_q  <= wdata_i[7:0];
      if (wr_i && hit.ien)  ien_q  <= wdata_i[7:0];
      if (wr_i && hit.cmp)  cmp_q  <= wdata_i;

      if (wr_cnt)
        cnt_q <= wdata_i;
      else if (tick)
        cnt_q <= (match && clr_mode) ? '0 : cnt_q + 1'b1;

      if (match)
        flag_q <= 1'b1;
      else if (ack_ok)
        flag_q <= 1'b0;

      if (wr_stat)
        armed_q <= 1'b0;
      else if (rd_stat && flag_q)
        armed_q <= 1'b1;
    end
  end

  always_comb begin
    rval_o = '0;
    unique case (1'b1)
      hit.ctrl: rval_o = CNT_W'(ctrl_q);
      hit.mode: rval_o = CNT_W'(mode_q);
      hit.ioc:  rval_o = CNT_W'(ioc_q);
      hit.ien:  rval_o = CNT_W'(ien_q);
      hit.stat: rval_o = CNT_W'(flag_q);
      hit.cnt:  rval_o = cnt_q;
      hit.cmp:  rval_o = cmp_q;
      default:  rval_o = '0;
    endcase
  end

  assign irq_o = flag_q & ien_q[0];

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_cnt) |=> $stable(cnt_q));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == cmp_q && clr_mode && !wr_cnt) |=> (cnt_q == '0));

  // R8
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(armed_q) && $past(wr_i));
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int IDX_W      = ADDR_W - OFF_W;
  localparam int START_ADDR = NUM_CH << OFF_W;

  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic              start_hit;
  logic [NUM_CH-1:0] run_q;
  logic [CNT_W-1:0]  rdata_q;
  logic [CNT_W-1:0]  rd_mux;
  logic [CNT_W-1:0]  ch_rval [NUM_CH];

  assign idx       = bus_addr[ADDR_W-1:OFF_W];
  assign off       = bus_addr[OFF_W-1:0];
  assign start_hit = (bus_addr == ADDR_W'(START_ADDR));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .run_i   (run_q[c]),
      .wr_i    (bus_we && (idx == IDX_W'(c))),
      .rd_i    (bus_re && (idx == IDX_W'(c))),
      .off_i   (off),
      .wdata_i (bus_wdata),
      .rval_o  (ch_rval[c]),
      .irq_o   (irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (start_hit) rd_mux = CNT_W'(run_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx == IDX_W'(c)) rd_mux = ch_rval[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_we && start_hit) run_q <= bus_wdata[NUM_CH-1:0];
      if (bus_re) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

  // R2
  byte_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (idx < IDX_W'(NUM_CH)) && is_byte_reg(off)) |=> (bus_rdata[CNT_W-1:8] == '0));
endmodule

// File: tb/cmt_timer_tb_top.sv
`timescale 1ns/1ps
module cmt_timer_tb_top;
  localparam int NCH     = 3;
  localparam int START_A = NCH * 16;

  logic        clk = 0, rst = 1, b_we = 0, b_re = 0;
  logic [7:0]  b_addr = 0;
  logic [15:0] b_wdata = 0;
  wire  [15:0] b_rdata;
  wire  [NCH-1:0] irq;

  always #4 clk = ~clk;

  cmt_timer #(.NUM_CH(NCH), .CNT_W(16), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_we(b_we), .bus_re(b_re), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq(irq));

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural model
  int m_ctrl[NCH], m_mode[NCH], m_ioc[NCH], m_ien[NCH];
  int m_flag[NCH], m_arm[NCH], m_cnt[NCH], m_cmp[NCH], m_pc[NCH];
  int m_run, m_rdata;

  function automatic int mread(int a);
    int ch, off;
    ch = a / 16; off = a % 16;
    if (a == START_A) return m_run;
    if (ch >= NCH) return 0;
    case (off)
      0: return m_ctrl[ch];
      1: return m_mode[ch];
      2: return m_ioc[ch];
      4: return m_ien[ch];
      5: return m_flag[ch];
      6: return m_cnt[ch];
      8: return m_cmp[ch];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int a, ch, off, d, dv, wv;
    bit tk, mt, wh, rh, oldf;
    a = b_addr; ch = a / 16; off = a % 16; d = b_wdata;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = 0; m_mode[c] = 0; m_ioc[c] = 0; m_ien[c] = 0; m_flag[c] = 0;
        m_arm[c] = 0; m_cnt[c] = 0; m_cmp[c] = 0; m_pc[c] = 0;
      end
      m_run = 0; m_rdata = 0;
    end else begin
      if (b_re) m_rdata = mread(a);
      for (int c = 0; c < NCH; c++) begin
        dv = 1 << (2 * (m_ctrl[c] % 4));
        tk = m_run[c] && (m_pc[c] >= dv - 1);
        mt = tk && (m_cnt[c] == m_cmp[c]);
        wh = b_we && (ch == c);
        rh = b_re && (ch == c);
        oldf = m_flag[c][0];
        if (!m_run[c] || tk) m_pc[c] = 0; else m_pc[c] = m_pc[c] + 1;
        if (wh && off == 6) m_cnt[c] = d;
        else if (tk) m_cnt[c] = (mt && ((m_ctrl[c] / 32) % 8 == 1)) ? 0 : (m_cnt[c] + 1) % 65536;
        if (mt) m_flag[c] = 1;
        else if (wh && off == 5 && m_arm[c] != 0 && d % 2 == 0) m_flag[c] = 0;
        if (wh && off == 5) m_arm[c] = 0;
        else if (rh && off == 5 && oldf) m_arm[c] = 1;
        wv = d % 256;
        if (wh && off == 0) m_ctrl[c] = wv;
        if (wh && off == 1) m_mode[c] = wv;
        if (wh && off == 2) m_ioc[c] = wv;
        if (wh && off == 4) m_ien[c] = wv;
        if (wh && off == 8) m_cmp[c] = d;
      end
      if (b_we && a == START_A) m_run = d % (1 << NCH);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int ei;
    ei = 0;
    for (int c = 0; c < NCH; c++)
      if (m_flag[c] != 0 && (m_ien[c] % 2) == 1) ei = ei | (1 << c);
    checks++;
    if (int'(irq) != ei) begin
      errors++;
      $display("FAIL %s irq act %b exp %b at %0t", cur_req, irq, ei[NCH-1:0], $time);
    end
    checks++;
    if (int'(b_rdata) != m_rdata) begin
      errors++;
      $display("FAIL %s rdata act %h exp %h at %0t", cur_req, b_rdata, m_rdata[15:0], $time);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); b_we = 1; b_addr = 8'(a); b_wdata = 16'(d);
    @(negedge clk); b_we = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); b_re = 1; b_addr = 8'(a);
    @(negedge clk); b_re = 0; v = b_rdata;
  endtask

  task automatic wait_irq(int c, output int n);
    n = 0;
    while (irq[c] == 1'b0 && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, n;
    repeat (4) @(negedge clk);
    rst = 0;

    cur_req = "R1";
    chk("R1 irq", int'(irq), 0);
    for (int c = 0; c < NCH; c++) begin
      rd(c * 16 + 0, v); chk("R1 ctrl", v, 0);
      rd(c * 16 + 6, v); chk("R1 cnt", v, 0);
      rd(c * 16 + 5, v); chk("R1 stat", v, 0);
    end
    rd(START_A, v); chk("R1 run", v, 0);

    cur_req = "R2";
    wr(32, 16'h00A5); rd(32, v); chk("R2 ctrl", v, 16'hA5);
    wr(33, 16'h1234); rd(33, v); chk("R2 mode byte", v, 16'h34);
    wr(34, 16'h005A); rd(34, v); chk("R2 ioc", v, 16'h5A);
    wr(36, 16'hFFC3); rd(36, v); chk("R2 ien", v, 16'hC3);
    wr(38, 16'hBEEF); rd(38, v); chk("R2 cnt", v, 16'hBEEF);
    wr(40, 16'h1357); rd(40, v); chk("R2 cmp", v, 16'h1357);
    wr(39, 16'hFFFF); rd(39, v); chk("R2 unmapped", v, 0);
    rd(38, v); chk("R2 cnt kept", v, 16'hBEEF);

    cur_req = "R4";
    wr(0, 16'h21); wr(8, 3); wr(6, 0); wr(4, 1);
    wr(START_A, 1);
    wait_irq(0, n); chk("R4 div4 latency", n, 16);
    wr(START_A, 0);
    wr(16, 16'h27); wr(24, 1); wr(22, 0); wr(20, 1);
    wr(START_A, 2);
    wait_irq(1, n); chk("R4 div64 latency", n, 128);
    wr(START_A, 0);
    rd(16 + 6, v); chk("R3 stopped counter", v, 0);
    idle_and_check: begin
      repeat (20) @(negedge clk);
      rd(16 + 6, v); chk("R3 counter holds", v, 0);
    end

    cur_req = "R8";
    wr(5, 16'hFE); chk("R8 no prior read", int'(irq[0]), 1);
    rd(5, v); chk("R8 flag read", v, 1);
    wr(5, 16'hFF); chk("R8 write one", int'(irq[0]), 1);
    wr(5, 16'hFE); chk("R8 disarmed", int'(irq[0]), 1);
    rd(5, v); wr(5, 16'hFE); chk("R8 ack", int'(irq[0]), 0);
    rd(5, v); chk("R8 flag cleared", v, 0);

    cur_req = "R9";
    wr(20, 0); chk("R9 masked", int'(irq[1]), 0);
    wr(20, 1); chk("R9 unmasked", int'(irq[1]), 1);

    cur_req = "R6";
    wr(32, 16'h00); wr(36, 0); wr(38, 16'hFFFD); wr(40, 1);
    wr(START_A, 4);
    repeat (10) @(negedge clk);
    rd(37, v); chk("R6 free-run flag", v, 1);
    rd(38, v);
    repeat (30) @(negedge clk);
    wr(START_A, 0);
    rd(38, v); chk("R6 no clear", (v > 20) ? 1 : 0, 1);

    cur_req = "R10";
    rd(21, v); wr(21, 16'hFE);
    wr(16, 16'h22); wr(24, 2); wr(22, 0);
    wr(START_A, 2);
    repeat (7) @(negedge clk);
    wr(START_A, 0);
    repeat (3) @(negedge clk);
    wr(START_A, 2);
    wait_irq(1, n); chk("R10 restart latency", n, 48);
    wr(START_A, 0);

    cur_req = "R11";
    rd(21, v); wr(21, 16'hFE);
    wr(0, 16'h20); wr(8, 2); wr(6, 0); wr(START_A, 1);
    for (int i = 0; i < 40; i++) begin
      rd(5, v); wr(5, 16'hFE);
      if (i % 7 == 0) wr(6, i % 3);
    end
    wr(START_A, 0);

    cur_req = "RND";
    for (int i = 0; i < 1500; i++) begin
      int ch, op, a, d;
      int offs[7] = '{0, 1, 2, 4, 5, 6, 8};
      ch = $urandom_range(0, NCH);
      a = (ch == NCH) ? START_A : ch * 16 + offs[$urandom_range(0, 6)];
      op = $urandom_range(0, 2);
      case (a % 16)
        0: d = ($urandom_range(0, 1) ? 16'h20 : 16'h00) | $urandom_range(0, 3);
        5: d = $urandom_range(0, 1) ? 16'hFE : 16'hFF;
        6, 8: d = $urandom_range(0, 20);
        default: d = $urandom_range(0, 65535);
      endcase
      if (a == START_A) d = $urandom_range(0, 7);
      if (op == 0) wr(a, d);
      else if (op == 1) rd(a, v);
      else @(negedge clk);
    end

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule